// File: doc/BRIEF.md
# Five-Bit Opcode Arithmetic, Logic and Shift Unit

This block is a purely combinational datapath unit. It takes two operands, `a` and `b`, and a 5-bit operation code. It drives a result word and a carry-out. The operations cover a pass of `a`, increment, decrement, addition, subtraction, three bitwise two-operand functions, complement of `a`, and a one-position shift of `a` in either direction.

The code map is sparse. The low three bits of the arithmetic codes pick what is added to `a` and whether a carry is injected. The remaining codes fall into a logic group and a shift group. Every code outside the eleven listed ones yields a zero result and a zero carry.

The unit sits between operand-selection multiplexers and a destination register that lie outside it. It has no clock and no state. The data width is a parameter and defaults to 8 bits.

Top module: `opsel_alu`

## Requirements
- R1: Code 00000 drives `y` equal to `a`, with `cout` at 0.
- R2: Code 00001 drives `y` = `a`+1 modulo 2^W, and `cout` is 1 exactly when `a` is all ones.
- R3: Code 00110 drives `y` = `a`-1 modulo 2^W. It is formed as `a` plus an all-ones word, so `cout` is 1 exactly when `a` is non-zero.
- R4: Code 00010 drives `y` = `a`+`b` modulo 2^W, and `cout` is the carry out of the top bit.
- R5: Code 00101 drives `y` = `a`-`b` modulo 2^W. It is formed as `a` + ~`b` + 1, so `cout` is 1 exactly when `a` >= `b` as unsigned values.
- R6: Codes 01000, 01010 and 01100 drive the bitwise AND, OR and XOR of `a` and `b` respectively, with `cout` at 0.
- R7: Code 01110 drives the bitwise complement of `a`, with `cout` at 0.
- R8: Code 10000 shifts `a` right by one position with a 0 entering the top bit, and `cout` equals bit 0 of `a`.
- R9: Code 11000 shifts `a` left by one position with a 0 entering bit 0, and `cout` equals the top bit of `a`.
- R10: Each of the 21 codes not named in R1 to R9 drives `y` = 0 and `cout` = 0, whatever the operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand; the one used by transfer, increment, decrement, complement and shifts |
| b | input | W | Second operand |
| op | input | 5 | Operation code |
| y | output | W | Result word |
| cout | output | 1 | Carry-out, or the bit shifted out |

## Verification
The bench drives operands at the wrap points: all ones, zero, the top bit alone, and the lowest bit alone. It also drives equal operands for subtraction.

A design that inverted the subtract carry would report a borrow when `a` equals `b`. A decrement built as a true subtraction would get the carry sense wrong at zero. A shifter that filled with the outgoing bit would behave as a rotate, and its top or bottom bit would fail.

All 32 codes are walked with non-zero operands. Any decode that lets a neighbouring code fall into an arithmetic or logic path therefore shows up as a non-zero result or carry.

// File: rtl/opsel_alu_pkg.sv
package opsel_alu_pkg;

  typedef enum logic [4:0] {
    OP_PASS = 5'b00000,
    OP_INC  = 5'b00001,
    OP_ADD  = 5'b00010,
    OP_SUB  = 5'b00101,
    OP_DEC  = 5'b00110,
    OP_AND  = 5'b01000,
    OP_OR   = 5'b01010,
    OP_XOR  = 5'b01100,
    OP_NOT  = 5'b01110,
    OP_SHR  = 5'b10000,
    OP_SHL  = 5'b11000
  } alu_op_e;

  typedef enum logic [2:0] {
    UNIT_ARITH,
    UNIT_LOGIC,
    UNIT_SHR,
    UNIT_SHL,
    UNIT_NONE
  } alu_unit_e;

  // Map an operation code onto the functional unit that serves it.
  function automatic alu_unit_e unit_of(input logic [4:0] code);
    alu_unit_e u;
    case (code)
      OP_PASS, OP_INC, OP_ADD, OP_SUB, OP_DEC: u = UNIT_ARITH;
      OP_AND, OP_OR, OP_XOR, OP_NOT:           u = UNIT_LOGIC;
      OP_SHR:                                  u = UNIT_SHR;
      OP_SHL:                                  u = UNIT_SHL;
      default:                                 u = UNIT_NONE;
    endcase
    return u;
  endfunction

endpackage

// File: rtl/opsel_arith.sv
// Single adder serving pass, increment, add, subtract and decrement.
// bsel picks the addend: 00 zero, 01 b, 10 ~b, 11 all ones.
module opsel_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   bsel,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int WE = W + 1;

  logic [W-1:0]  addend;
  logic [WE-1:0] total;

  always_comb begin
    case (bsel)
      2'b00:   addend = '0;
      2'b01:   addend = b;
      2'b10:   addend = ~b;
      default: addend = '1;
    endcase
    total = {1'b0, a} + {1'b0, addend} + {{W{1'b0}}, cin};
  end

  assign sum  = total[W-1:0];
  assign cout = total[WE-1];
endmodule

// File: rtl/opsel_logic.sv
// Bitwise unit; fsel: 00 AND, 01 OR, 10 XOR, 11 NOT a.
module opsel_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   fsel,
  output logic [W-1:0] res
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      case (fsel)
        2'b00:   res[i] = a[i] & b[i];
        2'b01:   res[i] = a[i] | b[i];
        2'b10:   res[i] = a[i] ^ b[i];
        default: res[i] = ~a[i];
      endcase
    end
  end
endmodule

// File: rtl/opsel_shift.sv
// One-position shift with zero fill; the outgoing bit leaves on cout.
module opsel_shift #(
  parameter int W    = 8,
  parameter bit LEFT = 1'b0
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] res,
  output logic         cout
);
  if (LEFT) begin : g_left
    assign res  = {a[W-2:0], 1'b0};
    assign cout = a[W-1];
  end else begin : g_right
    assign res  = {1'b0, a[W-1:1]};
    assign cout = a[0];
  end
endmodule

// File: rtl/opsel_alu.sv
module opsel_alu
  import opsel_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [4:0]   op,
  output logic [W-1:0] y,
  output logic         cout
);
  logic [W-1:0] arith_y, logic_y, shr_y, shl_y;
  logic         arith_c, shr_c, shl_c;
  alu_unit_e    unit;

  assign unit = unit_of(op);

  opsel_arith #(.W(W)) u_arith (
    .a    (a),
    .b    (b),
    .bsel (op[2:1]),
    .cin  (op[0]),
    .sum  (arith_y),
    .cout (arith_c)
  );

  opsel_logic #(.W(W)) u_logic (
    .a    (a),
    .b    (b),
    .fsel (op[2:1]),
    .res  (logic_y)
  );

  opsel_shift #(.W(W), .LEFT(1'b0)) u_shr (
    .a    (a),
    .res  (shr_y),
    .cout (shr_c)
  );

  opsel_shift #(.W(W), .LEFT(1'b1)) u_shl (
    .a    (a),
    .res  (shl_y),
    .cout (shl_c)
  );

  always_comb begin
    case (unit)
      UNIT_ARITH: begin y = arith_y; cout = arith_c; end
      UNIT_LOGIC: begin y = logic_y; cout = 1'b0;    end
      UNIT_SHR:   begin y = shr_y;   cout = shr_c;   end
      UNIT_SHL:   begin y = shl_y;   cout = shl_c;   end
      default:    begin y = '0;      cout = 1'b0;    end
    endcase
  end
endmodule

// File: rtl/opsel_alu_chk.sv
module opsel_alu_chk
  import opsel_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [4:0]   op,
  input logic [W-1:0] y,
  input logic         cout
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    if (!$isunknown({a, b, op, y, cout})) begin
      // R1
      pass_chk: assert (op != OP_PASS || (y == a && !cout));
      // R2
      inc_chk: assert (op != OP_INC || (W'(y - a) == ONE && cout == (y == '0)));
      // R3
      dec_chk: assert (op != OP_DEC || (W'(a - y) == ONE && cout == (y != '1)));
      // R4
      add_chk: assert (op != OP_ADD || (W'(y - b) == a && cout == (y < a)));
      // R5
      sub_chk: assert (op != OP_SUB || (W'(y + b) == a && cout == (a >= b)));
      // R6
      and_chk: assert (op != OP_AND || (((y & ~a) == '0) && ((y & ~b) == '0) && !cout));
      // R7
      not_chk: assert (op != OP_NOT || (((y & a) == '0) && ((y | a) == '1) && !cout));
      // R8
      shr_chk: assert (op != OP_SHR || (!y[W-1] && y[W-2:0] == a[W-1:1] && cout == a[0]));
      // R9
      shl_chk: assert (op != OP_SHL || (!y[0] && y[W-1:1] == a[W-2:0] && cout == a[W-1]));
      // R10
      unused_chk: assert (unit_of(op) != UNIT_NONE || (y == '0 && !cout));
    end
  end
endmodule

bind opsel_alu opsel_alu_chk #(.W(W)) u_chk (
  .a    (a),
  .b    (b),
  .op   (op),
  .y    (y),
  .cout (cout)
);

// File: tb/opsel_alu_bench.sv
`timescale 1ns/1ps
module opsel_alu_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [4:0]   op = 5'b00000;
  logic [W-1:0] y;
  logic         cout;
  int           total = 0;
  int           bad = 0;

  always #4 clk = ~clk;

  opsel_alu #(.W(W)) u_opsel_alu (
    .a(a), .b(b), .op(op), .y(y), .cout(cout)
  );

  logic [W-1:0] pats [8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h55, 8'hAA, 8'h3C};

  // Expected {cout, y}, written from the requirement text.
  function automatic logic [W:0] expect_of(input logic [4:0] c, input logic [W-1:0] x,
                                          input logic [W-1:0] z);
    logic [W:0] r;
    case (c)
      5'b00000: r = {1'b0, x};
      5'b00001: r = {x == '1, W'(x + 1)};
      5'b00110: r = {x != '0, W'(x - 1)};
      5'b00010: r = {1'b0, x} + {1'b0, z};
      5'b00101: r = {x >= z, W'(x - z)};
      5'b01000: r = {1'b0, x & z};
      5'b01010: r = {1'b0, x | z};
      5'b01100: r = {1'b0, x ^ z};
      5'b01110: r = {1'b0, ~x};
      5'b10000: r = {x[0], 1'b0, x[W-1:1]};
      5'b11000: r = {x[W-1], x[W-2:0], 1'b0};
      default:  r = '0;
    endcase
    return r;
  endfunction

  task automatic apply_check(input string req, input logic [4:0] c,
                             input logic [W-1:0] x, input logic [W-1:0] z);
    logic [W:0] e;
    @(negedge clk);
    op = c; a = x; b = z;
    #2;
    e = expect_of(c, x, z);
    total++;
    if ({cout, y} !== e) begin
      bad++;
      $display("FAIL %s op=%b a=%h b=%h: got cout=%b y=%h, expected cout=%b y=%h",
               req, c, x, z, cout, y, e[W], e[W-1:0]);
    end
  endtask

  task automatic t_initial();
    // R1: operands and code start at zero, so the result is zero.
    #2;
    total++;
    if (y !== '0 || cout !== 1'b0) begin
      bad++;
      $display("FAIL R1 initial: got cout=%b y=%h, expected cout=0 y=00", cout, y);
    end
  endtask

  task automatic t_pass();
    for (int i = 0; i < 8; i++) apply_check("R1", 5'b00000, pats[i], pats[7-i]);
  endtask

  task automatic t_incdec();
    for (int i = 0; i < 8; i++) apply_check("R2", 5'b00001, pats[i], 8'hFF);
    for (int i = 0; i < 8; i++) apply_check("R3", 5'b00110, pats[i], 8'h00);
  endtask

  task automatic t_addsub();
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        apply_check("R4", 5'b00010, pats[i], pats[j]);
        apply_check("R5", 5'b00101, pats[i], pats[j]);
      end
  endtask

  task automatic t_bitwise();
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        apply_check("R6", 5'b01000, pats[i], pats[j]);
        apply_check("R6", 5'b01010, pats[i], pats[j]);
        apply_check("R6", 5'b01100, pats[i], pats[j]);
      end
    for (int i = 0; i < 8; i++) apply_check("R7", 5'b01110, pats[i], pats[i]);
  endtask

  task automatic t_shift();
    for (int i = 0; i < 8; i++) apply_check("R8", 5'b10000, pats[i], 8'hFF);
    for (int i = 0; i < 8; i++) apply_check("R9", 5'b11000, pats[i], 8'hFF);
  endtask

  task automatic t_unused();
    // R10: the whole code space; listed codes are checked against their own rule.
    for (int c = 0; c < 32; c++) begin
      apply_check("R10", 5'(c), 8'hFF, 8'hFF);
      apply_check("R10", 5'(c), 8'h81, 8'h7E);
    end
  endtask

  initial begin
    t_initial();
    t_pass();
    t_incdec();
    t_addsub();
    t_bitwise();
    t_shift();
    t_unused();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule